// File: doc/BRIEF.md
# Character LCD Power-Up Initialiser

This block brings an 8-bit character LCD module from power-on to a usable state without any processor involvement. After reset it waits for the panel's supply to settle, sends the interface-width command three times with the unequal pauses the controller needs before it accepts commands, then configures the panel (two lines, 5×7 font, cursor auto-increment, display on with cursor and blink off). It clears the screen and holds off for the long clear time before raising `ready`.

Each command goes out as a single-cycle strobe with an 8-bit byte and a register-select flag, which is always low. A separate write engine handles the enable pulse and bus setup. All pauses are counted in clock cycles derived from the `CLK_HZ` parameter. Once `ready` is high, a client can ask for the cursor to be moved to a line and column. The block turns that request into a display-address command, then keeps `ready` low for the normal inter-command gap.

Top module: `lcd_boot_sequencer`

## Requirements
- R1: While `rst_n` is low, `wr_req` and `ready` are 0. Releasing reset always restarts the whole sequence from the power-on wait, including when reset arrives part-way through.
- R2: Count the clock edges from the first edge that samples `rst_n` high as edge 0. The first command, 0x38, is strobed T(15 ms) cycles later. Its strobe is registered at edge T(15 ms)-1.
- R3: The second 0x38 follows the first by T(4.1 ms) cycles. The third 0x38 follows the second by T(100 µs) cycles.
- R4: After the third 0x38, the commands 0x38, 0x06, 0x0C and 0x01 follow, in that order. Each is T(40 µs) cycles after the one before it.
- R5: Every command is a one-cycle `wr_req` strobe with `wr_rs` = 0. Exactly 7 commands are issued between reset and `ready`.
- R6: `ready` rises T(1.64 ms) cycles after the 0x01 strobe and never earlier.
- R7: A cursor request is taken when `cur_req` is high in a cycle where `ready` is high. With `cur_line` = 1 the command on the next cycle is 0x80 + `cur_col`. With `cur_line` = 2 it is 0xC0 + `cur_col`. `cur_col` runs from 0 to 15, and bit 7 of the command is always set.
- R8: Taking a cursor request drops `ready` in the same cycle as its strobe. `ready` returns T(40 µs) cycles later. Requests made while it is low produce no command.
- R9: Cursor requests made before the initialisation sequence finishes produce no command.
- R10: A request with `cur_line` equal to 0 or 3 is ignored. No strobe is issued and `ready` stays high.
- R11: T(t) = max(2, ceil(t × `CLK_HZ`)), computed from the parameter at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_req | input | 1 | Cursor-position request |
| cur_line | input | 2 | Target line, 1 or 2 |
| cur_col | input | 4 | Target column, 0 to 15 |
| wr_req | output | 1 | One-cycle command strobe to the write engine |
| wr_rs | output | 1 | Register select for the strobe (always 0, command) |
| wr_data | output | 8 | Command byte |
| ready | output | 1 | Initialisation done and idle |

## Verification
The bench keeps a cycle index that is 0 through reset and counts rising edges after release. It samples on falling edges, so a strobe registered at edge k is seen with index k+1. Every expected strobe and ready-rise index is the running sum of T(t) terms computed in the bench. A cursor command is due on the first falling edge after the request edge. `ready` must then stay low for 39 further falling edges and be high on the 40th. Ignored requests are judged by the strobe count and by `ready` a few cycles later.

// File: rtl/lcd_boot_pkg.sv
// Shared types and elaboration-time helpers for the LCD boot sequencer.
// Assumes times are given in tenths of a microsecond.
package lcd_boot_pkg;

    typedef enum logic [1:0] {
        ST_SCRIPT,  // walking the fixed command script
        ST_HOLD,    // final or post-cursor wait before ready
        ST_READY    // idle, cursor requests accepted
    } seq_state_t;

    // Clock cycles covering a time in 0.1 us units, rounded up, never below 2
    function automatic longint wait_cycles(longint tenth_us, longint clk_hz);
        longint c;
        c = (tenth_us * clk_hz + 64'd9_999_999) / 64'd10_000_000;
        if (c < 2) c = 2;
        return c;
    endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
// Down-counting wait timer. Reset preloads RST_VAL; a load takes precedence
// over counting; expired is high while the count sits at zero.
// Assumes load_val already has the "minus one" applied by the caller.
module lcd_wait_timer #(
    parameter int CW = 20,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Count down toward zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= RST_VAL;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_EXPIRED_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !load |=> expired); // R11

endmodule

// File: rtl/lcd_init_script.sv
// Fixed power-up command script: for each step index gives the command byte
// and the wait that follows it. Assumes step 0..6; wait values fit in CW bits.
module lcd_init_script #(
    parameter int CLK_HZ = 50_000_000,
    parameter int CW     = 20
) (
    input  logic [2:0]    step,
    output logic [7:0]    cmd,
    output logic [CW-1:0] wait_cyc
);
    localparam logic [CW-1:0] W_4M1  = CW'(lcd_boot_pkg::wait_cycles(41000, CLK_HZ));
    localparam logic [CW-1:0] W_100U = CW'(lcd_boot_pkg::wait_cycles(1000,  CLK_HZ));
    localparam logic [CW-1:0] W_40U  = CW'(lcd_boot_pkg::wait_cycles(400,   CLK_HZ));
    localparam logic [CW-1:0] W_1M64 = CW'(lcd_boot_pkg::wait_cycles(16400, CLK_HZ));

    localparam logic [7:0] C_WIDTH8 = 8'h38;
    localparam logic [7:0] C_ENTRY  = 8'h06;
    localparam logic [7:0] C_DISPON = 8'h0C;
    localparam logic [7:0] C_CLEAR  = 8'h01;

    // Step decode: byte sent at this step and pause after it
    always_comb begin
        case (step)
            3'd0:    begin cmd = C_WIDTH8; wait_cyc = W_4M1;  end
            3'd1:    begin cmd = C_WIDTH8; wait_cyc = W_100U; end
            3'd2:    begin cmd = C_WIDTH8; wait_cyc = W_40U;  end
            3'd3:    begin cmd = C_WIDTH8; wait_cyc = W_40U;  end
            3'd4:    begin cmd = C_ENTRY;  wait_cyc = W_40U;  end
            3'd5:    begin cmd = C_DISPON; wait_cyc = W_40U;  end
            default: begin cmd = C_CLEAR;  wait_cyc = W_1M64; end
        endcase
    end

endmodule

// File: rtl/lcd_cursor_map.sv
// Maps a line number (1 or 2) and a column to a display-address command.
// Assumes COLS is a power of two no larger than 64.
module lcd_cursor_map #(
    parameter int COLS = 16,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic [1:0]       line,
    input  logic [COL_W-1:0] col,
    output logic [7:0]       addr,
    output logic             ok
);
    localparam logic [7:0] ADDR_CMD = 8'h80;
    localparam logic [7:0] ROW2_OFS = 8'h40;

    // Only lines 1 and 2 exist; build the address command
    always_comb begin
        ok   = (line == 2'd1) || (line == 2'd2);
        addr = ADDR_CMD | ((line == 2'd2) ? ROW2_OFS : 8'h00) | 8'(col);
    end

endmodule

// File: rtl/lcd_boot_sequencer.sv
// Top: runs the LCD power-up command script after reset, then serves cursor
// moves. Each command is a one-cycle strobe to an external write engine that
// handles E timing; all pauses are counted here. Assumes the write engine
// accepts a strobe at any time.
module lcd_boot_sequencer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int COLS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_req,
    input  logic [1:0] cur_line,
    input  logic [3:0] cur_col,
    output logic       wr_req,
    output logic       wr_rs,
    output logic [7:0] wr_data,
    output logic       ready
);
    import lcd_boot_pkg::*;

    localparam longint W_PWR_L = wait_cycles(150000, CLK_HZ);
    localparam int     CW      = $clog2(W_PWR_L + 1);
    localparam logic [CW-1:0] W_PWR = CW'(W_PWR_L);
    localparam logic [CW-1:0] W_GAP = CW'(wait_cycles(400, CLK_HZ));
    localparam logic [2:0]    LAST_STEP = 3'd6;

    seq_state_t    state;
    logic [2:0]    step;
    logic [7:0]    scr_cmd;
    logic [CW-1:0] scr_wait;
    logic [7:0]    map_addr;
    logic          map_ok;
    logic          expired;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          take_cursor;

    lcd_init_script #(.CLK_HZ(CLK_HZ), .CW(CW)) u_script (
        .step     (step),
        .cmd      (scr_cmd),
        .wait_cyc (scr_wait)
    );

    lcd_cursor_map #(.COLS(COLS)) u_map (
        .line (cur_line),
        .col  (cur_col),
        .addr (map_addr),
        .ok   (map_ok)
    );

    lcd_wait_timer #(.CW(CW), .RST_VAL(W_PWR - 1'b1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    // Timer reload: after each script command, or after a cursor command
    always_comb begin
        take_cursor = (state == ST_READY) && cur_req && map_ok;
        tmr_load    = ((state == ST_SCRIPT) && expired) || take_cursor;
        tmr_val     = (state == ST_SCRIPT) ? (scr_wait - 1'b1) : (W_GAP - 1'b1);
    end

    // Sequencer: issue script commands, wait out final pause, serve cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SCRIPT;
            step    <= '0;
            wr_req  <= 1'b0;
            wr_data <= '0;
            ready   <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            case (state)
                ST_SCRIPT: if (expired) begin
                    wr_req  <= 1'b1;
                    wr_data <= scr_cmd;
                    if (step == LAST_STEP) state <= ST_HOLD;
                    else                   step  <= step + 1'b1;
                end
                ST_HOLD: if (expired) begin
                    ready <= 1'b1;
                    state <= ST_READY;
                end
                default: if (take_cursor) begin
                    wr_req  <= 1'b1;
                    wr_data <= map_addr;
                    ready   <= 1'b0;
                    state   <= ST_HOLD;
                end
            endcase
        end
    end

    assign wr_rs = 1'b0;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R5
    AST_NO_CMD_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !wr_req); // R6
    AST_CURSOR_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) && wr_req |-> wr_data[7]); // R7
    AST_CURSOR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cur_req && (cur_line == 2'd1 || cur_line == 2'd2) |=> wr_req && !ready); // R8
    AST_BAD_LINE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cur_req && (cur_line == 2'd0 || cur_line == 2'd3) |=> !wr_req && ready); // R10
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !ready && (state == ST_HOLD) && !expired |=> !wr_req); // R9

endmodule

// File: tb/lcd_boot_sequencer_tb.sv
// Bench: 50 MHz clock, CLK_HZ set to 1 MHz so one cycle stands for 1 us.
module lcd_boot_sequencer_tb;
    localparam int CLK_HZ = 1_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cur_req = 1'b0;
    logic [1:0] cur_line = 2'd0;
    logic [3:0] cur_col = 4'd0;
    logic       wr_req, wr_rs, ready;
    logic [7:0] wr_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int npulse = 0;
    int   p_t [64];
    logic [7:0] p_d [64];
    logic p_rs [64];

    lcd_boot_sequencer #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cur_req(cur_req), .cur_line(cur_line),
        .cur_col(cur_col), .wr_req(wr_req), .wr_rs(wr_rs), .wr_data(wr_data),
        .ready(ready)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Strobe logger, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) npulse = 0;
        else if (wr_req) begin
            if (npulse < 64) begin
                p_t[npulse] = cyc; p_d[npulse] = wr_data; p_rs[npulse] = wr_rs;
            end
            npulse = npulse + 1;
        end
    end

    function automatic int tcyc(longint tenth_us);
        longint c;
        c = (tenth_us * CLK_HZ + 64'd9_999_999) / 64'd10_000_000;
        if (c < 2) c = 2;
        return int'(c);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ready(output int when);
        when = -1;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (ready) begin when = cyc; break; end
        end
    endtask

    // Full script check against arithmetic expectations
    task automatic check_script(input int rdy_at);
        int exp_t [7];
        int exp_d [7];
        exp_d = '{8'h38, 8'h38, 8'h38, 8'h38, 8'h06, 8'h0C, 8'h01};
        exp_t[0] = tcyc(150000);
        exp_t[1] = exp_t[0] + tcyc(41000);
        exp_t[2] = exp_t[1] + tcyc(1000);
        for (int k = 3; k < 7; k++) exp_t[k] = exp_t[k-1] + tcyc(400);
        check(npulse == 7, "R5 command count", npulse, 7);
        for (int k = 0; k < 7; k++) begin
            check(p_d[k] == 8'(exp_d[k]), (k < 3) ? "R3 script byte" : "R4 script byte", p_d[k], exp_d[k]);
            check(p_t[k] == exp_t[k], (k == 0) ? "R2 first cmd time" : (k < 3 ? "R3 cmd time" : "R4 cmd time"), p_t[k], exp_t[k]);
            check(p_rs[k] == 1'b0, "R5 rs low", p_rs[k], 0);
        end
        check(rdy_at == exp_t[6] + tcyc(16400), "R6 ready time", rdy_at, exp_t[6] + tcyc(16400));
    endtask

    task automatic do_cursor(input logic [1:0] ln, input logic [3:0] col, input bit poke);
        int n0, expa;
        bit gap_ok;
        n0 = npulse;
        expa = ((ln == 2'd1) ? 128 : 192) + int'(col);
        cur_req = 1'b1; cur_line = ln; cur_col = col;
        @(negedge clk);
        cur_req = 1'b0;
        check(wr_req && wr_rs == 1'b0 && wr_data == 8'(expa) && !ready, "R7 cursor cmd", wr_data, expa);
        gap_ok = 1'b1;
        for (int i = 1; i < tcyc(400); i++) begin
            @(negedge clk);
            if (poke && i == 5) begin cur_req = 1'b1; cur_line = 2'd1; cur_col = 4'd0; end
            if (poke && i == 6) cur_req = 1'b0;
            if (ready) gap_ok = 1'b0;
        end
        @(negedge clk);
        check(gap_ok && ready, "R8 ready gap", ready, 1);
        @(negedge clk);
        check(npulse == n0 + 1, poke ? "R8 busy request ignored" : "R7 one cmd", npulse - n0, 1);
    endtask

    task automatic bad_line(input logic [1:0] ln);
        int n0;
        bit ok;
        n0 = npulse; ok = 1'b1;
        cur_req = 1'b1; cur_line = ln; cur_col = 4'd7;
        @(negedge clk);
        cur_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (wr_req || !ready) ok = 1'b0;
            @(negedge clk);
        end
        check(ok && npulse == n0, "R10 bad line ignored", npulse - n0, 0);
    endtask

    // Watchdog: expiry counts as a failure and still reaches the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        int rt;
        repeat (4) @(negedge clk);
        check(!wr_req && !ready, "R1 reset outputs", {wr_req, ready}, 0);
        rst_n = 1'b1;
        // R9: request held during most of the script must be ignored
        repeat (100) @(negedge clk);
        cur_req = 1'b1; cur_line = 2'd1; cur_col = 4'd5;
        while (cyc < 20900) @(negedge clk);
        cur_req = 1'b0;
        check(npulse == 7, "R9 early requests ignored", npulse, 7);
        wait_ready(rt);
        check_script(rt);

        // R7/R8: sweep both lines and every column
        for (int ln = 1; ln <= 2; ln++)
            for (int c = 0; c < 16; c++)
                do_cursor(2'(ln), 4'(c), 1'b0);
        do_cursor(2'd2, 4'd3, 1'b1);
        bad_line(2'd0);
        bad_line(2'd3);

        // R1: reset mid-script restarts from the power-on wait
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (cyc < tcyc(150000) + tcyc(41000) + 5) @(negedge clk);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!wr_req && !ready && npulse == 0, "R1 reset mid-script", npulse, 0);
        rst_n = 1'b1;
        wait_ready(rt);
        check(p_t[0] == tcyc(150000), "R1 restart first cmd", p_t[0], tcyc(150000));
        check_script(rt);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule